// File: doc/BRIEF.md
# Receive FIFO with Trigger and Flow-Control Thresholds

This block is the receive side of a buffered serial channel. Bytes arriving from a deserializer are written into a 16-entry byte queue. The host bus takes them out one at a time, oldest first. A control word holds two independent threshold selectors, and each selector indexes a fixed table:

- The receive-trigger level decides when the status word reports a "receive trigger reached" flag instead of a "data ready" flag.
- The flow-control limit drives a "can accept" output toward the far end.

A byte that arrives while the queue already holds 16 entries is dropped. The drop is recorded as an overrun in a separate line-status word, and reading that word clears it.

Occupancy is tracked by a four-state machine:

| State | Condition |
|-------|-----------|
| OCC_EMPTY | no bytes held |
| OCC_BELOW | some bytes held, fewer than the trigger level |
| OCC_ABOVE | trigger level reached, not full |
| OCC_FULL | 16 bytes held |

The state moves between these on four events:

- FILL: a push.
- DRAIN: a pop.
- RETUNE: a write to the control word that changes the trigger level.
- HOLD: no change.

The state register is loaded from the next level and the next trigger level. As a result, the count and both status flags change on the same clock edge.

Top module: `rx_fifo_trigger`

## Requirements
- R1: After reset the status word reads 0x0060, the level is 0, the line-status word is 0 and `rx_ready` is 1.
- R2: Bytes leave through `rd_byte` in the order they were accepted; `rd_byte` always shows the oldest held byte.
- R3: Control bits [8:7] select a trigger level from {0:1, 1:4, 2:8, 3:14}; while the level is at or above it, status bit 1 is 1 and status bit 0 is 0.
- R4: Below the trigger level status bit 1 is 0, and status bit 0 is 1 exactly when the level is nonzero.
- R5: Control bits [11:9] select a limit from {0:15, 1:1, 2:4, 3:6, 4:8, 5:10, 6:12, 7:14}; `rx_ready` is 1 exactly when the level is below the limit.
- R6: A byte offered while 16 bytes are held is dropped (contents and order unchanged) and sets line-status bit 0.
- R7: A line-status read returns the current value and clears it on the following edge, unless a new overrun happens in that same cycle, in which case bit 0 stays 1.
- R8: A push and a pop in the same cycle (neither empty nor full) keep the level unchanged and keep the byte order intact.
- R9: A pop while empty has no effect on level, status or later output order.
- R10: The level and the status flags update on the same edge after a push, a pop, or a control write that changes the trigger level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Deserializer offers a byte this cycle |
| rx_byte | input | DW | Offered byte |
| rx_ready | output | 1 | Flow-control: level below the selected limit |
| rd_pop | input | 1 | Bus removes the oldest byte |
| rd_byte | output | DW | Oldest held byte |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control word value |
| stat_word | output | 16 | Status word (bit 1 trigger reached, bit 0 data ready) |
| line_rd | input | 1 | Read strobe for the line-status word |
| line_word | output | 16 | Line-status word (bit 0 overrun) |
| rx_level | output | LW | Number of bytes held |

## Verification
The checker watches several rules on every cycle:

- The two status flags are never set together, and both are clear when the queue is empty.
- An offer at full leaves the level at 16 and raises the overrun bit.
- A combined push and pop keeps the level steady.
- A pop at empty leaves the level at zero.
- A line-status read with no coincident overrun leaves the word zero.
- A full queue never asserts `rx_ready`.

Other behaviour needs the bench's scenarios:

- Byte ordering across wrap-around.
- The exact table values behind both thresholds.
- Re-evaluation of the flags after a control write.
- The preservation of contents across a dropped byte.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_BELOW = 2'd1,
        OCC_ABOVE = 2'd2,
        OCC_FULL  = 2'd3
    } occ_e;

    localparam int          CTL_W        = 16;
    localparam int          TRIG_LSB     = 7;
    localparam int          TRIG_W       = 2;
    localparam int          FLOW_LSB     = 9;
    localparam int          FLOW_W       = 3;
    localparam int          ST_TRIG_BIT  = 1;
    localparam int          ST_READY_BIT = 0;
    localparam int          LS_OVR_BIT   = 0;
    localparam logic [15:0] STAT_RESET   = 16'h0060;

    // Receive-trigger table
    function automatic int unsigned trig_level(input logic [TRIG_W-1:0] sel);
        int unsigned r;
        unique case (sel)
            2'd0:    r = 1;
            2'd1:    r = 4;
            2'd2:    r = 8;
            default: r = 14;
        endcase
        return r;
    endfunction

    // Flow-control table: 15, 1, then twice the selector
    function automatic int unsigned flow_limit(input logic [FLOW_W-1:0] sel);
        int unsigned r;
        if (sel == '0)
            r = 15;
        else if (sel == 3'd1)
            r = 1;
        else
            r = 2 * int'(sel);
        return r;
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_en)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_ptr == AW'(i)))
                mem[i] <= wr_data;
        end
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/rxf_occ.sv
module rxf_occ
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic [LW-1:0] trig_nx,
    output logic [LW-1:0] level,
    output logic          do_push,
    output logic          do_pop,
    output logic          ovr_evt,
    output logic          flag_trig,
    output logic          flag_ready
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    occ_e          state_q, state_nx;
    logic [LW-1:0] lvl_nx;

    always_comb begin
        do_push = push_req && (level != FULL_LVL);
        do_pop  = pop_req  && (level != '0);
        ovr_evt = push_req && (level == FULL_LVL);
        lvl_nx  = level;
        if (do_push && !do_pop)
            lvl_nx = level + 1'b1;
        else if (do_pop && !do_push)
            lvl_nx = level - 1'b1;
    end

    // Next-state: FILL / DRAIN / RETUNE / HOLD all resolve through the next level
    always_comb begin
        if (lvl_nx == '0)
            state_nx = OCC_EMPTY;
        else if (lvl_nx == FULL_LVL)
            state_nx = OCC_FULL;
        else if (lvl_nx >= trig_nx)
            state_nx = OCC_ABOVE;
        else
            state_nx = OCC_BELOW;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            level   <= '0;
        end else begin
            state_q <= state_nx;
            level   <= lvl_nx;
        end
    end

    always_comb begin
        flag_trig  = 1'b0;
        flag_ready = 1'b0;
        unique case (state_q)
            OCC_EMPTY: ;
            OCC_BELOW: flag_ready = 1'b1;
            OCC_ABOVE: flag_trig  = 1'b1;
            OCC_FULL:  flag_trig  = 1'b1;
        endcase
    end

endmodule

// File: rtl/rxf_lsr.sv
module rxf_lsr
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ovr_evt,
    input  logic        rd,
    output logic [15:0] word
);
    logic ovr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_q <= 1'b0;
        else if (ovr_evt)
            ovr_q <= 1'b1;
        else if (rd)
            ovr_q <= 1'b0;
    end

    always_comb begin
        word             = '0;
        word[LS_OVR_BIT] = ovr_q;
    end

endmodule

// File: rtl/rx_fifo_trigger.sv
module rx_fifo_trigger
    import rxf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    output logic          rx_ready,
    input  logic          rd_pop,
    output logic [DW-1:0] rd_byte,
    input  logic          ctl_we,
    input  logic [15:0]   ctl_wdata,
    output logic [15:0]   stat_word,
    input  logic          line_rd,
    output logic [15:0]   line_word,
    output logic [LW-1:0] rx_level
);
    logic [CTL_W-1:0] ctl_q, ctl_nx;
    logic [LW-1:0]    trig_nx;
    logic [LW-1:0]    flow_lim;
    logic             do_push, do_pop, ovr_evt;
    logic             flag_trig, flag_ready;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else
            ctl_q <= ctl_nx;
    end

    always_comb begin
        ctl_nx   = ctl_we ? ctl_wdata : ctl_q;
        trig_nx  = LW'(trig_level(ctl_nx[TRIG_LSB +: TRIG_W]));
        flow_lim = LW'(flow_limit(ctl_q[FLOW_LSB +: FLOW_W]));
        rx_ready = rx_level < flow_lim;
    end

    rxf_occ #(.DEPTH(DEPTH), .LW(LW)) u_occ (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (rx_valid),
        .pop_req    (rd_pop),
        .trig_nx    (trig_nx),
        .level      (rx_level),
        .do_push    (do_push),
        .do_pop     (do_pop),
        .ovr_evt    (ovr_evt),
        .flag_trig  (flag_trig),
        .flag_ready (flag_ready)
    );

    rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_push),
        .wr_data (rx_byte),
        .rd_en   (do_pop),
        .rd_data (rd_byte)
    );

    rxf_lsr u_lsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovr_evt (ovr_evt),
        .rd      (line_rd),
        .word    (line_word)
    );

    always_comb begin
        stat_word               = STAT_RESET;
        stat_word[ST_TRIG_BIT]  = flag_trig;
        stat_word[ST_READY_BIT] = flag_ready;
    end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rd_pop,
    input logic          rx_ready,
    input logic          line_rd,
    input logic [15:0]   stat_word,
    input logic [15:0]   line_word,
    input logic [LW-1:0] rx_level
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_word[1] && stat_word[0]));                                   // R4
    AST_EMPTY_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> (stat_word[1:0] == 2'b00));                    // R4
    AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_level == FULL_LVL) |=> line_word[0]);              // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rd_pop && rx_level == FULL_LVL) |=> (rx_level == FULL_LVL)); // R6
    AST_PUSHPOP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rd_pop && rx_level != '0 && rx_level != FULL_LVL) |=> $stable(rx_level)); // R8
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && !rx_valid && rx_level == '0) |=> (rx_level == '0));    // R9
    AST_LINE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_rd && !(rx_valid && rx_level == FULL_LVL)) |=> (line_word == 16'h0000)); // R7
    AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == FULL_LVL) |-> !rx_ready);                             // R5

endmodule

bind rx_fifo_trigger rxf_checker #(.DEPTH(DEPTH), .LW(LW)) u_rxf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rd_pop    (rd_pop),
    .rx_ready  (rx_ready),
    .line_rd   (line_rd),
    .stat_word (stat_word),
    .line_word (line_word),
    .rx_level  (rx_level)
);

// File: tb/tb_rx_fifo_trigger.sv
`timescale 1ns/1ps
module tb_rx_fifo_trigger;
    localparam int DW = 8;
    localparam int DEPTH = 16;
    localparam int LW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] rx_byte = '0;
    logic          rx_ready;
    logic          rd_pop = 1'b0;
    logic [DW-1:0] rd_byte;
    logic          ctl_we = 1'b0;
    logic [15:0]   ctl_wdata = '0;
    logic [15:0]   stat_word;
    logic          line_rd = 1'b0;
    logic [15:0]   line_word;
    logic [LW-1:0] rx_level;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rx_fifo_trigger #(.DW(DW), .DEPTH(DEPTH)) dut (.*);

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic [7:0] b, input logic p, input logic lr);
        rx_valid = v; rx_byte = b; rd_pop = p; line_rd = lr;
        @(negedge clk);
        rx_valid = 0; rd_pop = 0; line_rd = 0;
    endtask

    task automatic push(input logic [7:0] b);
        cyc(1'b1, b, 1'b0, 1'b0);
    endtask

    task automatic pop_expect(input string tag, input logic [7:0] exp);
        check(tag, rd_byte, exp);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic drain();
        while (rx_level != 0) cyc(1'b0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 status", stat_word, 16'h0060);
        check("R1 level", rx_level, 0);
        check("R1 line", line_word, 0);
        check("R1 ready", rx_ready, 1);
    endtask

    task automatic t_order();
        wr_ctl(16'h0000);
        push(8'hA1);
        check("R3 trig1 at level1", stat_word, 16'h0062);
        push(8'hB2); push(8'hC3);
        pop_expect("R2 first", 8'hA1);
        pop_expect("R2 second", 8'hB2);
        pop_expect("R2 third", 8'hC3);
        check("R4 empty flags", stat_word, 16'h0060);
    endtask

    task automatic t_trigger();
        wr_ctl(16'h0100);
        for (int i = 0; i < 7; i++) push(8'(i));
        check("R4 below trig8", stat_word, 16'h0061);
        push(8'h07);
        check("R3 at trig8", stat_word, 16'h0062);
        wr_ctl(16'h0180);
        check("R10 retune to 14", stat_word, 16'h0061);
        wr_ctl(16'h0080);
        check("R10 retune to 4", stat_word, 16'h0062);
        for (int i = 0; i < 5; i++) cyc(1'b0, 8'h00, 1'b1, 1'b0);
        check("R10 pop re-eval level", rx_level, 3);
        check("R10 pop re-eval flags", stat_word, 16'h0061);
        drain();
        check("R4 drained", stat_word, 16'h0060);
    endtask

    task automatic t_flow();
        wr_ctl(16'h0200);
        check("R5 limit1 empty", rx_ready, 1);
        push(8'h11);
        check("R5 limit1 one held", rx_ready, 0);
        wr_ctl(16'h0E00);
        for (int i = 0; i < 12; i++) push(8'(i));
        check("R5 limit14 at 13", rx_ready, 1);
        push(8'h22);
        check("R5 limit14 at 14", rx_ready, 0);
        wr_ctl(16'h0000);
        check("R5 limit15 at 14", rx_ready, 1);
        drain();
    endtask

    task automatic t_overrun();
        wr_ctl(16'h0000);
        for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
        check("R6 no overrun yet", line_word, 0);
        push(8'hEE);
        check("R6 level held", rx_level, 16);
        check("R6 overrun bit", line_word, 16'h0001);
        cyc(1'b1, 8'hEF, 1'b0, 1'b1);
        check("R7 read with new overrun", line_word, 16'h0001);
        check("R7 value before read", line_word, 16'h0001);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        check("R7 cleared after read", line_word, 16'h0000);
        for (int i = 0; i < 16; i++) pop_expect("R6 contents kept", 8'(8'h40 + i));
        check("R6 empty after drain", rx_level, 0);
    endtask

    task automatic t_pushpop();
        push(8'h10); push(8'h11); push(8'h12);
        check("R8 head", rd_byte, 8'h10);
        cyc(1'b1, 8'h13, 1'b1, 1'b0);
        check("R8 level steady", rx_level, 3);
        pop_expect("R8 order a", 8'h11);
        pop_expect("R8 order b", 8'h12);
        pop_expect("R8 order c", 8'h13);
    endtask

    task automatic t_empty_pop();
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        check("R9 level", rx_level, 0);
        check("R9 status", stat_word, 16'h0060);
        push(8'h55);
        pop_expect("R9 later order", 8'h55);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_trigger();
        t_flow();
        t_overrun();
        t_pushpop();
        t_empty_pop();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule